// File: doc/BRIEF.md
# In-DRAM Row Copy Command Sequencer

This block sits inside a DRAM memory controller and turns one row-copy request into a short burst of DRAM commands. The request names a bank, a source row and a destination row, and both rows belong to one subarray. The sequencer opens the source row, closes the bank after a deliberately shortened active time, and reopens it on the destination row after a deliberately shortened precharge time. The sense amplifiers still hold the source data, so that data is written into the destination row. Each operation moves one whole 8 KiB row.

An initialization request works the same way. Its source is a row of the same subarray that already holds all zeros, and the address of that row comes with the request. After the destination activate, the sequencer waits a normal active time and closes the bank with a legal precharge. If the bank has an open row when the request is accepted, the sequencer first closes it with a legal precharge and the full precharge time.

The two shortened gaps are held in registers that can be changed while the block is idle. Both are counted in controller clock cycles. While a sequence runs, the sequencer owns the command port, and no other command reaches any bank.

Top module: `rdc_row_copier`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `cmd` is NOP. The shortened active gap and the shortened precharge gap both start at SHORT_RAS_RST = 2 and SHORT_RP_RST = 2 cycles.
- R2: Command codes are NOP = 0, ACT = 1 and PRE = 2. A copy issues, all to the requested bank, ACT(source row), then PRE, then ACT(destination row), then PRE. `cmd_row` is 0 on every PRE.
- R3: The gap from the source ACT to the next PRE equals the programmed shortened active gap. The gap from that PRE to the destination ACT equals the programmed shortened precharge gap.
- R4: The final PRE comes T_RAS_NORM = 5 cycles after the destination ACT. `done` is high T_RP_NORM = 2 cycles after the final PRE, and `req_ready` returns to 1 in that same cycle.
- R5: When `req_init` is 1, the source ACT uses `req_zero_row`, and `req_src_row` has no effect.
- R6: If `bank_open` has the bit of the requested bank set at acceptance, a PRE to that bank comes first, and the source ACT follows T_RP_NORM cycles later.
- R7: The first command appears on the port in the cycle after the clock edge that accepts the request (`req_valid` and `req_ready` both high).
- R8: `req_ready` is low from acceptance until `done`. Requests offered while busy are ignored, and `cmd` is NOP whenever no sequence is running.
- R9: A configuration write (`cfg_we`) while idle sets both shortened gaps for later requests. A written value of 0 is stored as 1. A write while busy is ignored.
- R10: `done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write both shortened gap registers |
| cfg_short_ras | input | CNT_W | New shortened active gap, in cycles |
| cfg_short_rp | input | CNT_W | New shortened precharge gap, in cycles |
| bank_open | input | 2**BANK_W | Per-bank open-row flags from the bank tracker |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_init | input | 1 | 1 = zero-initialization, 0 = copy |
| req_bank | input | BANK_W | Target bank |
| req_src_row | input | ROW_W | Source row for a copy |
| req_zero_row | input | ROW_W | All-zero row used as source for initialization |
| req_dst_row | input | ROW_W | Destination row |
| cmd | output | 2 | Command code (0 NOP, 1 ACT, 2 PRE) |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row of an ACT, 0 otherwise |
| done | output | 1 | One-cycle completion pulse |

## Verification
Writes and requests that arrive while a sequence is running are the hardest cases to produce, because a well-behaved controller would not offer them. The stimulus therefore raises `req_valid` with different fields, and pulses `cfg_we` with new gap values, in the cycles just after an acceptance. Any unwanted acceptance would put commands on the port that the scoreboard does not expect. A write that took effect would show up as changed gaps in the next request. The open-bank lead-in precharge is reached by setting the matching `bank_open` bit only during the accepting cycle.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_PRE = 2'd2
  } dram_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE_OPEN,
    S_ACT_SRC,
    S_PRE_MID,
    S_ACT_DST,
    S_PRE_END,
    S_SETTLE
  } seq_state_e;
endpackage

// File: rtl/rdc_timing_cfg.sv
module rdc_timing_cfg #(
  parameter int CNT_W         = 6,
  parameter int SHORT_RAS_RST = 2,
  parameter int SHORT_RP_RST  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle,
  input  logic             we,
  input  logic [CNT_W-1:0] ras_in,
  input  logic [CNT_W-1:0] rp_in,
  output logic [CNT_W-1:0] ras_q,
  output logic [CNT_W-1:0] rp_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q <= CNT_W'(SHORT_RAS_RST);
      rp_q  <= CNT_W'(SHORT_RP_RST);
    end else if (we && idle) begin
      ras_q <= (ras_in == '0) ? ONE : ras_in;
      rp_q  <= (rp_in  == '0) ? ONE : rp_in;
    end
  end

  // R9: gaps never drop to zero cycles
  p_gap_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    (ras_q != '0) && (rp_q != '0));

  // R9: registers frozen while a sequence runs
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable(ras_q) && $stable(rp_q));
endmodule

// File: rtl/rdc_gap_timer.sv
module rdc_gap_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R3: the timer steps down by one each idle cycle
  p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rdc_row_copier.sv
module rdc_row_copier
  import rdc_pkg::*;
#(
  parameter int BANK_W        = 3,
  parameter int ROW_W         = 14,
  parameter int CNT_W         = 6,
  parameter int T_RAS_NORM    = 5,
  parameter int T_RP_NORM     = 2,
  parameter int SHORT_RAS_RST = 2,
  parameter int SHORT_RP_RST  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [CNT_W-1:0]         cfg_short_ras,
  input  logic [CNT_W-1:0]         cfg_short_rp,
  input  logic [(1<<BANK_W)-1:0]   bank_open,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_init,
  input  logic [BANK_W-1:0]        req_bank,
  input  logic [ROW_W-1:0]         req_src_row,
  input  logic [ROW_W-1:0]         req_zero_row,
  input  logic [ROW_W-1:0]         req_dst_row,
  output logic [1:0]               cmd,
  output logic [BANK_W-1:0]        cmd_bank,
  output logic [ROW_W-1:0]         cmd_row,
  output logic                     done
);
  localparam logic [CNT_W-1:0] RAS_N_M1 = CNT_W'(T_RAS_NORM - 1);
  localparam logic [CNT_W-1:0] RP_N_M1  = CNT_W'(T_RP_NORM - 1);

  seq_state_e         state_q;
  dram_cmd_e          cmd_q;
  logic [BANK_W-1:0]  cmd_bank_q, bank_q;
  logic [ROW_W-1:0]   cmd_row_q, src_q, dst_q;
  logic               ready_q, done_q;
  logic [CNT_W-1:0]   short_ras, short_rp;
  logic               t_load, t_zero;
  logic [CNT_W-1:0]   t_val;

  rdc_timing_cfg #(
    .CNT_W(CNT_W), .SHORT_RAS_RST(SHORT_RAS_RST), .SHORT_RP_RST(SHORT_RP_RST)
  ) u_cfg (
    .clk(clk), .rst(rst), .idle(ready_q), .we(cfg_we),
    .ras_in(cfg_short_ras), .rp_in(cfg_short_rp),
    .ras_q(short_ras), .rp_q(short_rp)
  );

  rdc_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_zero)
  );

  // Gap that follows the command issued in this state
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (t_zero) begin
      case (state_q)
        S_PRE_OPEN: begin t_load = 1'b1; t_val = RP_N_M1;           end
        S_ACT_SRC:  begin t_load = 1'b1; t_val = short_ras - 1'b1;  end
        S_PRE_MID:  begin t_load = 1'b1; t_val = short_rp - 1'b1;   end
        S_ACT_DST:  begin t_load = 1'b1; t_val = RAS_N_M1;          end
        S_PRE_END:  begin t_load = 1'b1; t_val = RP_N_M1;           end
        default:    begin t_load = 1'b0; t_val = '0;                end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      ready_q    <= 1'b1;
      done_q     <= 1'b0;
      cmd_q      <= CMD_NOP;
      cmd_bank_q <= '0;
      cmd_row_q  <= '0;
      bank_q     <= '0;
      src_q      <= '0;
      dst_q      <= '0;
    end else begin
      cmd_q      <= CMD_NOP;
      cmd_bank_q <= '0;
      cmd_row_q  <= '0;
      done_q     <= 1'b0;
      case (state_q)
        S_IDLE: if (req_valid) begin
          bank_q  <= req_bank;
          src_q   <= req_init ? req_zero_row : req_src_row;
          dst_q   <= req_dst_row;
          ready_q <= 1'b0;
          state_q <= bank_open[req_bank] ? S_PRE_OPEN : S_ACT_SRC;
        end
        S_PRE_OPEN: if (t_zero) begin
          cmd_q <= CMD_PRE; cmd_bank_q <= bank_q; state_q <= S_ACT_SRC;
        end
        S_ACT_SRC: if (t_zero) begin
          cmd_q <= CMD_ACT; cmd_bank_q <= bank_q; cmd_row_q <= src_q;
          state_q <= S_PRE_MID;
        end
        S_PRE_MID: if (t_zero) begin
          cmd_q <= CMD_PRE; cmd_bank_q <= bank_q; state_q <= S_ACT_DST;
        end
        S_ACT_DST: if (t_zero) begin
          cmd_q <= CMD_ACT; cmd_bank_q <= bank_q; cmd_row_q <= dst_q;
          state_q <= S_PRE_END;
        end
        S_PRE_END: if (t_zero) begin
          cmd_q <= CMD_PRE; cmd_bank_q <= bank_q; state_q <= S_SETTLE;
        end
        S_SETTLE: if (t_zero) begin
          done_q <= 1'b1; ready_q <= 1'b1; state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = ready_q;
  assign cmd       = cmd_q;
  assign cmd_bank  = cmd_bank_q;
  assign cmd_row   = cmd_row_q;
  assign done      = done_q;

  // R8: no command on the port while the block accepts requests
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd != 2'd0) |-> !req_ready);

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: first command one cycle after the accepting edge
  p_first_cmd_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> ##1 (cmd != 2'd0));

  // R4: ready only comes back together with done
  p_ready_with_done_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready) |-> done);

  // R2: only defined command codes appear
  p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
    cmd != 2'd3);
endmodule

// File: tb/rdc_row_copier_test.sv
module rdc_row_copier_test;
  localparam int BW = 3, RW = 14, CW = 6;
  localparam int RAS_N = 5, RP_N = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [CW-1:0] cfg_short_ras = '0, cfg_short_rp = '0;
  logic [(1<<BW)-1:0] bank_open = '0;
  logic req_valid = 1'b0, req_ready, req_init = 1'b0;
  logic [BW-1:0] req_bank = '0;
  logic [RW-1:0] req_src_row = '0, req_zero_row = '0, req_dst_row = '0;
  logic [1:0] cmd;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic done;

  rdc_row_copier #(.BANK_W(BW), .ROW_W(RW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_short_ras(cfg_short_ras),
    .cfg_short_rp(cfg_short_rp), .bank_open(bank_open), .req_valid(req_valid),
    .req_ready(req_ready), .req_init(req_init), .req_bank(req_bank),
    .req_src_row(req_src_row), .req_zero_row(req_zero_row),
    .req_dst_row(req_dst_row), .cmd(cmd), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .done(done)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {int kind; int bank; int row; int stamp; string tag;} exp_t;
  exp_t q[$];
  int cyc = 0, nchk = 0, nfail = 0;
  int cur_ras = 2, cur_rp = 2;
  bit done_prev = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic take(int kind, int bank, int row);
    exp_t e;
    if (q.size() == 0) begin
      check(0, "R8", "unexpected event kind", kind, -1);
      return;
    end
    e = q.pop_front();
    check(e.kind == kind, e.tag, "event kind", kind, e.kind);
    check(e.bank == bank && e.row == row, e.tag, "bank*65536+row",
          bank * 65536 + row, e.bank * 65536 + e.row);
    check(e.stamp == cyc, e.tag, "cycle stamp", cyc, e.stamp);
  endtask

  // Monitor: compares port activity against the scoreboard queue
  always @(negedge clk) begin
    if (!rst) begin
      if (done_prev) check(done == 1'b0, "R10", "done second cycle", done, 0);
      done_prev = done;
      if (cmd == 2'd3) check(0, "R2", "illegal cmd code", cmd, 0);
      if (cmd != 2'd0) take(cmd, cmd_bank, (cmd == 2'd2) ? (cmd_row == 0 ? 0 : -int'(cmd_row)) : cmd_row);
      if (done) begin
        take(3, 0, 0);
        check(req_ready == 1'b1, "R4", "ready with done", req_ready, 1);
      end
    end
  end

  // Driver: offers one request and pushes the expected events
  task automatic send(int bank, int src, int zrow, int dst, bit init,
                      bit open, bit disturb, string tag);
    int t, srow;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_bank = BW'(bank); req_src_row = RW'(src); req_zero_row = RW'(zrow);
    req_dst_row = RW'(dst); req_init = init; req_valid = 1'b1;
    bank_open = '0;
    if (open) bank_open[bank] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; bank_open = '0;
    check(req_ready == 1'b0, "R8", "ready after accept", req_ready, 0);
    srow = init ? zrow : src;
    t = cyc + 1;
    if (open) begin
      q.push_back('{2, bank, 0, t, "R6"});
      t += RP_N;
    end
    q.push_back('{1, bank, srow, t, init ? "R5" : tag});
    t += cur_ras;
    q.push_back('{2, bank, 0, t, tag});
    t += cur_rp;
    q.push_back('{1, bank, dst, t, tag});
    t += RAS_N;
    q.push_back('{2, bank, 0, t, "R4"});
    t += RP_N;
    q.push_back('{3, 0, 0, t, "R4"});
    if (disturb) begin
      // R8 and R9: requests and config writes while busy must do nothing
      req_valid = 1'b1; req_bank = BW'(bank + 1); req_dst_row = 14'h0AAA;
      cfg_we = 1'b1; cfg_short_ras = 6'd7; cfg_short_rp = 6'd7;
      repeat (3) @(negedge clk);
      check(req_ready == 1'b0, "R8", "ready while busy", req_ready, 0);
      req_valid = 1'b0; cfg_we = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic write_cfg(int ras, int rp);
    @(negedge clk);
    cfg_we = 1'b1; cfg_short_ras = CW'(ras); cfg_short_rp = CW'(rp);
    @(negedge clk);
    cfg_we = 1'b0;
    cur_ras = (ras == 0) ? 1 : ras;
    cur_rp  = (rp == 0) ? 1 : rp;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got %0d expected %0d", 20000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    check(cmd == 2'd0, "R1", "cmd in reset", cmd, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(cmd == 2'd0 && req_ready, "R8", "idle port quiet", cmd, 0);
    // R1 R2 R3 R7: plain copy with reset gap values
    send(3, 14'h0120, 14'h3FF0, 14'h0121, 0, 0, 0, "R3");
    // R5: initialization, source field ignored
    send(1, 14'h0123, 14'h3FF0, 14'h0200, 1, 0, 0, "R2");
    // R6: bank already open
    send(5, 14'h0010, 0, 14'h0011, 0, 1, 0, "R6");
    // R9: new gaps, then zero clamps to one
    write_cfg(4, 3);
    send(2, 14'h1000, 0, 14'h1001, 0, 0, 0, "R9");
    write_cfg(0, 0);
    send(7, 14'h2000, 0, 14'h2002, 1, 0, 0, "R9");
    // R8 R9: traffic and writes during a sequence ignored
    write_cfg(3, 2);
    send(0, 14'h0044, 0, 14'h0045, 0, 0, 1, "R8");
    send(4, 14'h0050, 0, 14'h0051, 0, 0, 0, "R9");
    repeat (5) @(negedge clk);
    check(q.size() == 0 && cmd == 2'd0, "R8", "quiet at end", int'(q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule